// File: doc/BRIEF.md
# Decimal and ASCII Correction Unit

This unit applies the decimal correction steps of a 16-bit accumulator machine to an accumulator held as a high byte and a low byte. A 3-bit operation code picks one of six corrections: two that turn a binary add or subtract result into one unpacked decimal digit, one that splits a binary product of up to 99 into two unpacked digits, one that folds two unpacked digits into a binary byte ahead of a divide, and two that repair a packed two-digit BCD byte after an add or a subtract. The two remaining codes pass the operands through unchanged.

The unit uses the incoming half-carry (AF) and carry (CF) flags. It returns the new high and low bytes together with new AF, CF, zero (ZF), sign (SF) and parity (PF) flags. All outputs are registered, so a result appears one clock after its operands are sampled. The unit does not perform the add, subtract or multiply that comes before a correction.

Top module: `dadj_unit`

## Requirements
- R1: While `rst_n` is low, every output is held at 0.
- R2: Outputs show the result for the inputs sampled at the previous rising clock edge. They do not change between edges.
- R3: Op 0 (unpacked add correction) fires when the low nibble of the low byte is above 9 or AF is 1. When it fires, the low nibble becomes (low byte + 6) mod 16, the high byte is incremented, and AF and CF are set to 1. Otherwise the low nibble is kept, the high byte is kept, and AF and CF are cleared. In both cases the upper nibble of the low byte becomes 0.
- R4: Op 1 (unpacked subtract correction) uses the same firing condition as R3. When it fires, it subtracts 6 from the low byte and decrements the high byte, with the same flag and nibble-clearing rules as R3.
- R5: Op 2 (product split) sets the high byte to (low byte / 10) and the low byte to (low byte mod 10).
- R6: Op 3 (fold before divide) sets the low byte to (high byte × 10 + low byte) mod 256 and clears the high byte.
- R7: Op 4 (packed add correction) adds 6 when the low nibble is above 9 or AF is 1, and sets AF in that case; otherwise it clears AF.
- R8: Both packed corrections (op 4 and op 5) also apply 60H to the byte when the original low byte is above 99H or CF is 1. In that case CF is set; otherwise CF is cleared. Packed corrections leave the high byte unchanged.
- R9: Op 5 (packed subtract correction) subtracts 6 under the R7 condition, with the same AF rule as R7, and subtracts 60H under the R8 condition.
- R10: For every op, ZF = 1 when the new low byte is 0, SF = bit 7 of the new low byte, and PF = 1 when the new low byte has an even number of one bits.
- R11: Ops 6 and 7 return the high byte, the low byte, AF and CF unchanged.
- R12: Ops 2 and 3 clear AF and CF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_in | input | 3 | Correction select (codes as in R3–R11) |
| hi_in | input | 8 | High byte of the accumulator |
| lo_in | input | 8 | Low byte of the accumulator |
| af_in | input | 1 | Incoming half-carry flag |
| cf_in | input | 1 | Incoming carry flag |
| hi_out | output | 8 | Corrected high byte |
| lo_out | output | 8 | Corrected low byte |
| af_out | output | 1 | New half-carry flag |
| cf_out | output | 1 | New carry flag |
| zf_out | output | 1 | New zero flag |
| sf_out | output | 1 | New sign flag |
| pf_out | output | 1 | New parity flag (1 = even) |

## Verification
The hardest cases to reach are the packed corrections where both digit fixes fire at once. They matter most at the byte's edges: a low byte near FFH with AF set, where the add wraps, and a low byte below 06H with flags set, where the subtract borrows through zero. These cases depend on the incoming flags as well as on the byte value. The stimulus therefore sweeps all 256 low-byte values under all four AF/CF combinations for every op code. Each result is compared with an arithmetic model of the corrections written in the bench, and the six worked examples are also run as named checks.

// File: rtl/dadj_pkg.sv
package dadj_pkg;
   localparam int DADJ_BYTE_W = 8;

   typedef enum logic [2:0] {
      DA_ASC_ADD   = 3'd0,
      DA_ASC_SUB   = 3'd1,
      DA_BIN_SPLIT = 3'd2,
      DA_BIN_FOLD  = 3'd3,
      DA_PK_ADD    = 3'd4,
      DA_PK_SUB    = 3'd5,
      DA_PASS_A    = 3'd6,
      DA_PASS_B    = 3'd7
   } dadj_op_e;

   typedef struct packed {
      logic [DADJ_BYTE_W-1:0] hi;
      logic [DADJ_BYTE_W-1:0] lo;
      logic                   af;
      logic                   cf;
   } dadj_res_t;
endpackage

// File: rtl/dadj_ascii.sv
module dadj_ascii #(
   parameter int DIGIT_W  = 4,
   parameter bit SUBTRACT = 1'b0
) (
   input  logic [2*DIGIT_W-1:0] hi_i,
   input  logic [2*DIGIT_W-1:0] lo_i,
   input  logic                 af_i,
   output logic [2*DIGIT_W-1:0] hi_o,
   output logic [2*DIGIT_W-1:0] lo_o,
   output logic                 fire_o
);
   localparam int              BW   = 2 * DIGIT_W;
   localparam logic [DIGIT_W-1:0] MAXD = DIGIT_W'(9);
   localparam logic [BW-1:0]   SIX  = BW'(6);
   localparam logic [BW-1:0]   ONE  = BW'(1);

   initial assert (DIGIT_W == 4) else $error("dadj_ascii: DIGIT_W must be 4");

   logic [BW-1:0] lo_adj, hi_adj, lo_sel;

   assign fire_o = (lo_i[DIGIT_W-1:0] > MAXD) | af_i;

   generate
      if (SUBTRACT) begin : g_sub
         assign lo_adj = lo_i - SIX;
         assign hi_adj = hi_i - ONE;
      end else begin : g_add
         assign lo_adj = lo_i + SIX;
         assign hi_adj = hi_i + ONE;
      end
   endgenerate

   assign lo_sel = fire_o ? lo_adj : lo_i;
   assign lo_o   = {{DIGIT_W{1'b0}}, lo_sel[DIGIT_W-1:0]};
   assign hi_o   = fire_o ? hi_adj : hi_i;
endmodule

// File: rtl/dadj_packed.sv
module dadj_packed #(
   parameter int DIGIT_W  = 4,
   parameter bit SUBTRACT = 1'b0
) (
   input  logic [2*DIGIT_W-1:0] lo_i,
   input  logic                 af_i,
   input  logic                 cf_i,
   output logic [2*DIGIT_W-1:0] lo_o,
   output logic                 af_o,
   output logic                 cf_o
);
   localparam int                 BW     = 2 * DIGIT_W;
   localparam logic [DIGIT_W-1:0] MAXD   = DIGIT_W'(9);
   localparam logic [BW-1:0]      MAXB   = {MAXD, MAXD};
   localparam logic [BW-1:0]      LO_FIX = BW'(6);
   localparam logic [BW-1:0]      HI_FIX = LO_FIX << DIGIT_W;

   initial assert (DIGIT_W == 4) else $error("dadj_packed: DIGIT_W must be 4");

   logic [BW-1:0] step1;

   assign af_o = (lo_i[DIGIT_W-1:0] > MAXD) | af_i;
   assign cf_o = (lo_i > MAXB) | cf_i;

   generate
      if (SUBTRACT) begin : g_sub
         assign step1 = af_o ? (lo_i - LO_FIX) : lo_i;
         assign lo_o  = cf_o ? (step1 - HI_FIX) : step1;
      end else begin : g_add
         assign step1 = af_o ? (lo_i + LO_FIX) : lo_i;
         assign lo_o  = cf_o ? (step1 + HI_FIX) : step1;
      end
   endgenerate
endmodule

// File: rtl/dadj_conv.sv
module dadj_conv #(
   parameter int DIGIT_W = 4
) (
   input  logic [2*DIGIT_W-1:0] hi_i,
   input  logic [2*DIGIT_W-1:0] lo_i,
   output logic [2*DIGIT_W-1:0] split_hi_o,
   output logic [2*DIGIT_W-1:0] split_lo_o,
   output logic [2*DIGIT_W-1:0] fold_lo_o
);
   localparam int            BW   = 2 * DIGIT_W;
   localparam logic [BW-1:0] TEN  = BW'(10);

   initial assert (DIGIT_W == 4) else $error("dadj_conv: DIGIT_W must be 4");

   logic [2*BW-1:0] fold_wide;

   assign split_hi_o = lo_i / TEN;
   assign split_lo_o = lo_i % TEN;
   assign fold_wide  = ({{BW{1'b0}}, hi_i} * {{BW{1'b0}}, TEN}) + {{BW{1'b0}}, lo_i};
   assign fold_lo_o  = fold_wide[BW-1:0];
endmodule

// File: rtl/dadj_unit.sv
module dadj_unit #(
   parameter int DIGIT_W = 4,
   parameter bit OUT_REG = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [2:0]           op_in,
   input  logic [2*DIGIT_W-1:0] hi_in,
   input  logic [2*DIGIT_W-1:0] lo_in,
   input  logic                 af_in,
   input  logic                 cf_in,
   output logic [2*DIGIT_W-1:0] hi_out,
   output logic [2*DIGIT_W-1:0] lo_out,
   output logic                 af_out,
   output logic                 cf_out,
   output logic                 zf_out,
   output logic                 sf_out,
   output logic                 pf_out
);
   import dadj_pkg::*;

   localparam int BW = 2 * DIGIT_W;

   initial assert (BW == DADJ_BYTE_W) else $error("dadj_unit: byte width mismatch");

   logic [BW-1:0] aa_hi, aa_lo, as_hi, as_lo;
   logic          aa_fire, as_fire;
   logic [BW-1:0] pa_lo, ps_lo;
   logic          pa_af, pa_cf, ps_af, ps_cf;
   logic [BW-1:0] sp_hi, sp_lo, fd_lo;

   dadj_ascii #(.DIGIT_W(DIGIT_W), .SUBTRACT(1'b0)) u_asc_add (
      .hi_i(hi_in), .lo_i(lo_in), .af_i(af_in),
      .hi_o(aa_hi), .lo_o(aa_lo), .fire_o(aa_fire));

   dadj_ascii #(.DIGIT_W(DIGIT_W), .SUBTRACT(1'b1)) u_asc_sub (
      .hi_i(hi_in), .lo_i(lo_in), .af_i(af_in),
      .hi_o(as_hi), .lo_o(as_lo), .fire_o(as_fire));

   dadj_packed #(.DIGIT_W(DIGIT_W), .SUBTRACT(1'b0)) u_pk_add (
      .lo_i(lo_in), .af_i(af_in), .cf_i(cf_in),
      .lo_o(pa_lo), .af_o(pa_af), .cf_o(pa_cf));

   dadj_packed #(.DIGIT_W(DIGIT_W), .SUBTRACT(1'b1)) u_pk_sub (
      .lo_i(lo_in), .af_i(af_in), .cf_i(cf_in),
      .lo_o(ps_lo), .af_o(ps_af), .cf_o(ps_cf));

   dadj_conv #(.DIGIT_W(DIGIT_W)) u_conv (
      .hi_i(hi_in), .lo_i(lo_in),
      .split_hi_o(sp_hi), .split_lo_o(sp_lo), .fold_lo_o(fd_lo));

   dadj_res_t nxt;

   always_comb begin
      nxt = '{hi: hi_in, lo: lo_in, af: af_in, cf: cf_in};
      case (dadj_op_e'(op_in))
         DA_ASC_ADD:   nxt = '{hi: aa_hi, lo: aa_lo, af: aa_fire, cf: aa_fire};
         DA_ASC_SUB:   nxt = '{hi: as_hi, lo: as_lo, af: as_fire, cf: as_fire};
         DA_BIN_SPLIT: nxt = '{hi: sp_hi, lo: sp_lo, af: 1'b0, cf: 1'b0};
         DA_BIN_FOLD:  nxt = '{hi: '0, lo: fd_lo, af: 1'b0, cf: 1'b0};
         DA_PK_ADD:    nxt = '{hi: hi_in, lo: pa_lo, af: pa_af, cf: pa_cf};
         DA_PK_SUB:    nxt = '{hi: hi_in, lo: ps_lo, af: ps_af, cf: ps_cf};
         default:      nxt = '{hi: hi_in, lo: lo_in, af: af_in, cf: cf_in};
      endcase
   end

   logic nxt_zf, nxt_sf, nxt_pf;
   assign nxt_zf = (nxt.lo == '0);
   assign nxt_sf = nxt.lo[BW-1];
   assign nxt_pf = ~^nxt.lo;

   generate
      if (OUT_REG) begin : g_reg
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               hi_out <= '0;
               lo_out <= '0;
               af_out <= 1'b0;
               cf_out <= 1'b0;
               zf_out <= 1'b0;
               sf_out <= 1'b0;
               pf_out <= 1'b0;
            end else begin
               hi_out <= nxt.hi;
               lo_out <= nxt.lo;
               af_out <= nxt.af;
               cf_out <= nxt.cf;
               zf_out <= nxt_zf;
               sf_out <= nxt_sf;
               pf_out <= nxt_pf;
            end
         end

         AST_RESET_ZERO: assert property (@(posedge clk)
            $past(!rst_n) |-> (hi_out == '0 && lo_out == '0 && !af_out && !cf_out)); // R1
         AST_UNPACKED_TOP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && ($past(op_in) == 3'd0 || $past(op_in) == 3'd1))
            |-> (lo_out[BW-1:DIGIT_W] == '0 && af_out == cf_out)); // R3
         AST_SPLIT_DIGIT: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(op_in) == 3'd2) |-> (lo_out < BW'(10) && !af_out && !cf_out)); // R5
         AST_FOLD_HI_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(op_in) == 3'd3) |-> (hi_out == '0)); // R6
         AST_PACKED_HI_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && ($past(op_in) == 3'd4 || $past(op_in) == 3'd5))
            |-> (hi_out == $past(hi_in))); // R8
         AST_PASS_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(op_in) >= 3'd6)
            |-> (lo_out == $past(lo_in) && cf_out == $past(cf_in))); // R11
         AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
            zf_out |-> (lo_out == '0 && !sf_out && pf_out)); // R10
      end else begin : g_comb
         assign hi_out = nxt.hi;
         assign lo_out = nxt.lo;
         assign af_out = nxt.af;
         assign cf_out = nxt.cf;
         assign zf_out = nxt_zf;
         assign sf_out = nxt_sf;
         assign pf_out = nxt_pf;
      end
   endgenerate
endmodule

// File: tb/tb_dadj_unit.sv
module tb_dadj_unit;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] op_in = '0;
   logic [7:0] hi_in = '0, lo_in = '0;
   logic       af_in = 1'b0, cf_in = 1'b0;
   logic [7:0] hi_out, lo_out;
   logic       af_out, cf_out, zf_out, sf_out, pf_out;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   dadj_unit dut (
      .clk(clk), .rst_n(rst_n), .op_in(op_in), .hi_in(hi_in), .lo_in(lo_in),
      .af_in(af_in), .cf_in(cf_in), .hi_out(hi_out), .lo_out(lo_out),
      .af_out(af_out), .cf_out(cf_out), .zf_out(zf_out), .sf_out(sf_out),
      .pf_out(pf_out));

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic void model(input int op, input int hi, input int lo,
                                 input int af, input int cf,
                                 output int eh, output int el,
                                 output int eaf, output int ecf);
      int t;
      eh = hi; el = lo; eaf = af; ecf = cf;
      case (op)
         0: if ((lo % 16) > 9 || af != 0) begin
               el = (lo + 6) % 16; eh = (hi + 1) % 256; eaf = 1; ecf = 1;
            end else begin
               el = lo % 16; eaf = 0; ecf = 0;
            end
         1: if ((lo % 16) > 9 || af != 0) begin
               el = (lo + 250) % 16; eh = (hi + 255) % 256; eaf = 1; ecf = 1;
            end else begin
               el = lo % 16; eaf = 0; ecf = 0;
            end
         2: begin eh = lo / 10; el = lo % 10; eaf = 0; ecf = 0; end
         3: begin el = (hi * 10 + lo) % 256; eh = 0; eaf = 0; ecf = 0; end
         4, 5: begin
            t = lo; eaf = 0; ecf = 0;
            if ((lo % 16) > 9 || af != 0) begin
               t = (op == 4) ? (t + 6) % 256 : (t + 250) % 256; eaf = 1;
            end
            if (lo > 153 || cf != 0) begin
               t = (op == 4) ? (t + 96) % 256 : (t + 160) % 256; ecf = 1;
            end
            el = t;
         end
         default: ;
      endcase
   endfunction

   function automatic string op_req(input int op);
      case (op)
         0: return "R3";
         1: return "R4";
         2: return "R5";
         3: return "R6";
         4: return "R7";
         5: return "R9";
         default: return "R11";
      endcase
   endfunction

   task automatic run_vec(input int op, input int hi, input int lo,
                          input int af, input int cf);
      int eh, el, eaf, ecf, ones;
      string rq, fq;
      model(op, hi, lo, af, cf, eh, el, eaf, ecf);
      @(negedge clk);
      op_in = op[2:0]; hi_in = hi[7:0]; lo_in = lo[7:0];
      af_in = af[0];   cf_in = cf[0];
      @(negedge clk);
      rq = op_req(op);
      fq = (op == 2 || op == 3) ? "R12" : ((op == 4 || op == 5) ? "R8" : rq);
      chk(int'(hi_out) == eh, (op == 4 || op == 5) ? "R8" : rq, "hi", hi_out, eh);
      chk(int'(lo_out) == el, rq, "lo", lo_out, el);
      chk(int'(af_out) == eaf, (op == 4 || op == 5) ? "R7" : fq, "af", af_out, eaf);
      chk(int'(cf_out) == ecf, fq, "cf", cf_out, ecf);
      ones = 0;
      for (int b = 0; b < 8; b++) ones += (el >> b) & 1;
      chk(int'(zf_out) == int'(el == 0), "R10", "zf", zf_out, int'(el == 0));
      chk(int'(sf_out) == (el >> 7), "R10", "sf", sf_out, el >> 7);
      chk(int'(pf_out) == int'(ones % 2 == 0), "R10", "pf", pf_out, int'(ones % 2 == 0));
   endtask

   initial begin
      repeat (2000000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      op_in = 3'd4; hi_in = 8'h55; lo_in = 8'hAB; af_in = 1'b1; cf_in = 1'b1;
      repeat (3) @(negedge clk);
      // R1: held at zero in reset despite active inputs
      chk({hi_out, lo_out, af_out, cf_out, zf_out, sf_out, pf_out} == '0, "R1",
          "reset outputs", {hi_out, lo_out}, 0);
      rst_n = 1'b1;

      // Worked examples
      run_vec(0, 8'h00, 8'h67, 0, 0);
      chk(lo_out == 8'h07, "R3", "example 67H", lo_out, 8'h07);
      run_vec(2, 8'h00, 8'h24, 0, 0);
      chk({hi_out, lo_out} == 16'h0306, "R5", "example 0024H", {hi_out, lo_out}, 16'h0306);
      run_vec(3, 8'h05, 8'h08, 0, 0);
      chk({hi_out, lo_out} == 16'h003A, "R6", "example 0508H", {hi_out, lo_out}, 16'h003A);
      run_vec(4, 8'h00, 8'h7C, 0, 0);
      chk(lo_out == 8'h82, "R7", "example 7CH", lo_out, 8'h82);
      run_vec(5, 8'h00, 8'h2F, 1, 0);
      chk(lo_out == 8'h29, "R9", "example 2FH", lo_out, 8'h29);
      run_vec(1, 8'h03, 8'h0F, 0, 0);
      chk({hi_out, lo_out} == 16'h0209, "R4", "subtract wrap", {hi_out, lo_out}, 16'h0209);

      // R2: outputs hold until the next rising edge, then follow the inputs
      @(negedge clk);
      op_in = 3'd6; hi_in = 8'hA5; lo_in = 8'h3C; af_in = 1'b0; cf_in = 1'b1;
      @(negedge clk);
      op_in = 3'd6; hi_in = 8'h11; lo_in = 8'h22;
      #5;
      chk({hi_out, lo_out} == 16'hA53C, "R2", "hold between edges", {hi_out, lo_out}, 16'hA53C);
      @(negedge clk);
      chk({hi_out, lo_out} == 16'h1122, "R2", "update after edge", {hi_out, lo_out}, 16'h1122);

      // Exhaustive sweep of every op, low byte and flag pair
      for (int op = 0; op < 8; op++)
         for (int lo = 0; lo < 256; lo++)
            for (int fl = 0; fl < 4; fl++)
               run_vec(op, (lo * 37 + fl * 91 + op * 13 + 11) % 256, lo, fl & 1, fl >> 1);

      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule